// File: doc/BRIEF.md
# Cartridge Bank Mapping Controller

This block sits on the CPU and PPU buses of an 8-bit game-console cartridge and turns a handful of write-only control registers into the upper address lines of the program ROM, a chip select for the work RAM, the nametable mirroring select and the remapped address lines of the character RAM. Software chooses between two program layouts. The first is a 16 KiB switchable window at $8000-$BFFF with a semi-fixed upper window at $C000-$FFFF. The second is a single 32 KiB switchable window.

A one-bit-per-pixel video mode swaps two character-RAM address lines for values captured when PPU A13 last rose. This lets the 8 KiB character RAM hold a full bitmap screen. A bit-banged serial EEPROM port provides two chip selects, a clock and a data line. The EEPROM's data pin is read back inverted through a read-only location.

All registers are cleared by reset. The upper program window then shows bank $1F, which holds the reset vector. Register writes are sampled on the rising edge of `clk` while `cpu_we` is high. The ROM, the RAM and the EEPROM themselves are outside the block.

Top module: `cart_bank_ctrl`

## Requirements
- R1: After reset every register is zero. A CPU address with A14=1 gives `prg_addr_hi` = 7'h1F, and one with A14=0 gives 7'h00. Nametable mirroring is vertical (`nt_sel` follows PPU A10). All serial outputs are low.
- R2: A write is decoded only from `cpu_addr[15:8]`. Page $50 is bank-low, $51 is bank-high, $52 is the serial port and $53 is mirroring, whatever the low address byte. Writes to any other page leave every output unchanged.
- R3: When bank-low bit 4 (mode) is 0 and CPU A14=0, `prg_addr_hi[4:0]` is {bank-low bit 5, bank-low bits 3..0}.
- R4: When the mode bit is 0 and CPU A14=1, `prg_addr_hi[4:0]` is 5'b11111 if bank-low bit 6 is 0. If bank-low bit 6 is 1, it is {3'b111, bank-low bit 0, 1'b0}.
- R5: When the mode bit is 1, `prg_addr_hi[0]` equals CPU A14 and `prg_addr_hi[4:1]` equals bank-low bits 3..0.
- R6: `prg_addr_hi[6:5]` equals bank-high bits 1..0 in both modes.
- R7: When the mode bit is 0, mirroring is vertical. When it is 1, mirroring register bit 7 selects it: 1 is vertical (`nt_sel` = PPU A10) and 0 is horizontal (`nt_sel` = PPU A11).
- R8: A write to the serial port sets `mw_do` from data bit 0, `mw_clk` from bit 2, `mw_cs1` from bit 4 and `mw_cs2` from bit 6. The new values are visible after the write's clock edge.
- R9: A read with `cpu_re` high on page $55 drives `cpu_rdata_oe` high and returns {5'b0, ~`mw_di`, 2'b0}. Any other cycle leaves `cpu_rdata_oe` low and `cpu_rdata` zero.
- R10: With bank-low bit 7 set and PPU A13=0, `chr_addr` bit 3 takes PPU A0 and bit 12 takes PPU A9, both as captured at the first clock with A13 high after A13 was low. Later changes while A13 stays high are not captured. With the bit clear, `chr_addr` equals PPU A12..A0.
- R11: `prg_ram_cs` is high exactly for CPU addresses $6000-$7FFF. `prg_ram_addr` is CPU A10..A0, so the 2 KiB part repeats across the window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low reset |
| cpu_addr | input | 16 | CPU address |
| cpu_wdata | input | 8 | CPU write data |
| cpu_we | input | 1 | Write strobe, one cycle per write |
| cpu_re | input | 1 | Read strobe |
| cpu_rdata | output | 8 | Read data |
| cpu_rdata_oe | output | 1 | Read data drive enable |
| prg_addr_hi | output | 7 | Program ROM address A20..A14 |
| prg_ram_cs | output | 1 | Work RAM select |
| prg_ram_addr | output | 11 | Work RAM address |
| ppu_addr | input | 14 | PPU address A13..A0 |
| chr_addr | output | 13 | Character RAM address |
| nt_sel | output | 1 | Nametable select line |
| mw_di | input | 1 | EEPROM data from device |
| mw_do | output | 1 | EEPROM data to device |
| mw_clk | output | 1 | EEPROM serial clock |
| mw_cs1 | output | 1 | First EEPROM chip select |
| mw_cs2 | output | 1 | Second EEPROM chip select |

## Verification
The program mapping is tried with bank values whose outer bits differ, for example $25 and $1A, in both CPU halves and both modes. This shows whether the top bank bit, the low bit and the fixed-bank select are routed to the correct lines. Writes with non-zero low address bytes and writes to unused pages show whether the decode really masks with $FF00. In the bitmap mode, A0 and A9 are set during an A13 rise and changed afterwards while A13 stays high. This separates capture on the edge from a transparent pass.

// File: rtl/cart_pkg.sv
package cart_pkg;
   localparam logic [7:0] PG_BANK_LO = 8'h50;
   localparam logic [7:0] PG_BANK_HI = 8'h51;
   localparam logic [7:0] PG_SERIAL  = 8'h52;
   localparam logic [7:0] PG_MIRROR  = 8'h53;
   localparam logic [7:0] PG_SER_IN  = 8'h55;

   typedef struct packed {
      logic       bitmap_en;
      logic       fix_sel;
      logic       bank_top;
      logic       wide_mode;
      logic [3:0] bank_lo;
   } bank_lo_t;
endpackage

// File: rtl/cart_regs.sv
module cart_regs
   import cart_pkg::*;
#(
   parameter int HI_W = 2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [15:0]     addr,
   input  logic [7:0]      wdata,
   input  logic            we,
   output bank_lo_t        lo_q,
   output logic [HI_W-1:0] hi_q,
   output logic [3:0]      ser_q,
   output logic            mirror_v_q
);
   logic [7:0] page;
   assign page = addr[15:8];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lo_q       <= '0;
         hi_q       <= '0;
         ser_q      <= '0;
         mirror_v_q <= 1'b0;
      end else if (we) begin
         case (page)
            PG_BANK_LO: lo_q       <= bank_lo_t'(wdata);
            PG_BANK_HI: hi_q       <= wdata[HI_W-1:0];
            PG_SERIAL:  ser_q      <= {wdata[6], wdata[4], wdata[2], wdata[0]};
            PG_MIRROR:  mirror_v_q <= wdata[7];
            default: ;
         endcase
      end
   end

   AST_FOREIGN_PAGE_NO_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
      (we && page != PG_BANK_LO && page != PG_BANK_HI && page != PG_SERIAL && page != PG_MIRROR)
      |=> ($stable(lo_q) && $stable(hi_q) && $stable(ser_q) && $stable(mirror_v_q))); // R2

   AST_SERIAL_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      (we && page == PG_SERIAL) |=> (ser_q[2] == $past(wdata[4]) && ser_q[0] == $past(wdata[0]))); // R8
endmodule

// File: rtl/cart_prg_map.sv
module cart_prg_map
   import cart_pkg::*;
#(
   parameter int HI_W = 2,
   localparam int OUT_W = HI_W + 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cpu_a14,
   input  bank_lo_t         lo,
   input  logic [HI_W-1:0]  hi,
   output logic [OUT_W-1:0] prg_hi
);
   logic [4:0] low5;

   always_comb begin
      if (lo.wide_mode)
         low5 = {lo.bank_lo, cpu_a14};
      else if (!cpu_a14)
         low5 = {lo.bank_top, lo.bank_lo};
      else if (lo.fix_sel)
         low5 = {3'b111, lo.bank_lo[0], 1'b0};
      else
         low5 = 5'b11111;
   end

   assign prg_hi = {hi, low5};

   AST_WIDE_A14_PASS: assert property (@(posedge clk) disable iff (!rst_n)
      lo.wide_mode |-> (prg_hi[0] == cpu_a14)); // R5

   AST_FIXED_TOP: assert property (@(posedge clk) disable iff (!rst_n)
      (!lo.wide_mode && cpu_a14) |-> (prg_hi[4:2] == 3'b111 && prg_hi[0] == !lo.fix_sel)); // R4
endmodule

// File: rtl/cart_chr_map.sv
module cart_chr_map (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        bitmap_en,
   input  logic        vertical,
   input  logic [13:0] ppu_addr,
   output logic [12:0] chr_addr,
   output logic        nt_sel
);
   logic a13_q, cap_a0, cap_a9;
   logic rise;
   assign rise = ppu_addr[13] && !a13_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         a13_q  <= 1'b0;
         cap_a0 <= 1'b0;
         cap_a9 <= 1'b0;
      end else begin
         a13_q <= ppu_addr[13];
         if (rise) begin
            cap_a0 <= ppu_addr[0];
            cap_a9 <= ppu_addr[9];
         end
      end
   end

   always_comb begin
      chr_addr = ppu_addr[12:0];
      if (bitmap_en && !ppu_addr[13]) begin
         chr_addr[3]  = cap_a0;
         chr_addr[12] = cap_a9;
      end
   end

   assign nt_sel = vertical ? ppu_addr[10] : ppu_addr[11];

   AST_CHR_PASSTHRU: assert property (@(posedge clk) disable iff (!rst_n)
      !bitmap_en |-> (chr_addr == ppu_addr[12:0])); // R10

   AST_CAPTURE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (ppu_addr[13] && a13_q) |=> $stable(cap_a0) && $stable(cap_a9)); // R10
endmodule

// File: rtl/cart_bank_ctrl.sv
module cart_bank_ctrl
   import cart_pkg::*;
#(
   parameter int PRG_HI_W = 2,
   parameter int RAM_AW   = 11,
   localparam int PRG_W   = PRG_HI_W + 5,
   localparam int RAM_OW  = (RAM_AW > 0) ? RAM_AW : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [15:0]       cpu_addr,
   input  logic [7:0]        cpu_wdata,
   input  logic              cpu_we,
   input  logic              cpu_re,
   output logic [7:0]        cpu_rdata,
   output logic              cpu_rdata_oe,
   output logic [PRG_W-1:0]  prg_addr_hi,
   output logic              prg_ram_cs,
   output logic [RAM_OW-1:0] prg_ram_addr,
   input  logic [13:0]       ppu_addr,
   output logic [12:0]       chr_addr,
   output logic              nt_sel,
   input  logic              mw_di,
   output logic              mw_do,
   output logic              mw_clk,
   output logic              mw_cs1,
   output logic              mw_cs2
);
   if (PRG_HI_W < 1 || PRG_HI_W > 6) begin : g_bad_hi
      $error("PRG_HI_W out of range");
   end
   if (RAM_AW < 0 || RAM_AW > 13) begin : g_bad_ram
      $error("RAM_AW out of range");
   end

   bank_lo_t            lo_q;
   logic [PRG_HI_W-1:0] hi_q;
   logic [3:0]          ser_q;
   logic                mirror_v_q;
   logic                vertical;

   cart_regs #(.HI_W(PRG_HI_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .addr(cpu_addr), .wdata(cpu_wdata), .we(cpu_we),
      .lo_q(lo_q), .hi_q(hi_q), .ser_q(ser_q), .mirror_v_q(mirror_v_q)
   );

   cart_prg_map #(.HI_W(PRG_HI_W)) u_prg (
      .clk(clk), .rst_n(rst_n), .cpu_a14(cpu_addr[14]), .lo(lo_q), .hi(hi_q),
      .prg_hi(prg_addr_hi)
   );

   assign vertical = !lo_q.wide_mode || mirror_v_q;

   cart_chr_map u_chr (
      .clk(clk), .rst_n(rst_n), .bitmap_en(lo_q.bitmap_en), .vertical(vertical),
      .ppu_addr(ppu_addr), .chr_addr(chr_addr), .nt_sel(nt_sel)
   );

   assign {mw_cs2, mw_cs1, mw_clk, mw_do} = ser_q;

   if (RAM_AW > 0) begin : g_ram
      assign prg_ram_cs   = (cpu_addr[15:13] == 3'b011);
      assign prg_ram_addr = cpu_addr[RAM_OW-1:0];
   end else begin : g_no_ram
      assign prg_ram_cs   = 1'b0;
      assign prg_ram_addr = '0;
   end

   assign cpu_rdata_oe = cpu_re && (cpu_addr[15:8] == PG_SER_IN);
   assign cpu_rdata    = cpu_rdata_oe ? {5'b0, ~mw_di, 2'b0} : 8'h00;

   AST_READ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !cpu_re |-> (!cpu_rdata_oe && cpu_rdata == 8'h00)); // R9

   AST_HIGH_BANK_BITS: assert property (@(posedge clk) disable iff (!rst_n)
      prg_addr_hi[PRG_W-1:5] == hi_q); // R6

   AST_RAM_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
      prg_ram_cs |-> (cpu_addr >= 16'h6000 && cpu_addr <= 16'h7FFF)); // R11
endmodule

// File: tb/tb_cart_bank_ctrl.sv
module tb_cart_bank_ctrl;
   localparam int CLK_P = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] cpu_addr = '0;
   logic [7:0]  cpu_wdata = '0;
   logic        cpu_we = 1'b0, cpu_re = 1'b0;
   logic [7:0]  cpu_rdata;
   logic        cpu_rdata_oe;
   logic [6:0]  prg_addr_hi;
   logic        prg_ram_cs;
   logic [10:0] prg_ram_addr;
   logic [13:0] ppu_addr = '0;
   logic [12:0] chr_addr;
   logic        nt_sel;
   logic        mw_di = 1'b0;
   logic        mw_do, mw_clk, mw_cs1, mw_cs2;

   int checks = 0, errors = 0;

   always #(CLK_P/2) clk = ~clk;

   cart_bank_ctrl dut (
      .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
      .cpu_we(cpu_we), .cpu_re(cpu_re), .cpu_rdata(cpu_rdata), .cpu_rdata_oe(cpu_rdata_oe),
      .prg_addr_hi(prg_addr_hi), .prg_ram_cs(prg_ram_cs), .prg_ram_addr(prg_ram_addr),
      .ppu_addr(ppu_addr), .chr_addr(chr_addr), .nt_sel(nt_sel), .mw_di(mw_di),
      .mw_do(mw_do), .mw_clk(mw_clk), .mw_cs1(mw_cs1), .mw_cs2(mw_cs2)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [15:0] a, input logic [7:0] d);
      @(negedge clk);
      cpu_addr = a; cpu_wdata = d; cpu_we = 1'b1;
      @(negedge clk);
      cpu_we = 1'b0;
   endtask

   function automatic logic [6:0] ref_prg(input logic [7:0] lo, input logic [1:0] hi, input logic a14);
      logic [4:0] l;
      if (lo[4])         l = {lo[3:0], a14};
      else if (!a14)     l = {lo[5], lo[3:0]};
      else if (lo[6])    l = {3'b111, lo[0], 1'b0};
      else               l = 5'b11111;
      return {hi, l};
   endfunction

   task automatic prg_at(input string req, input logic [15:0] a, input logic [6:0] exp);
      @(negedge clk);
      cpu_addr = a;
      #1 chk(req, {25'b0, prg_addr_hi}, {25'b0, exp});
   endtask

   task automatic t_reset;
      prg_at("R1", 16'hFFFC, 7'h1F);
      prg_at("R1", 16'h8000, 7'h00);
      ppu_addr = 14'h0400;
      #1 chk("R1", {31'b0, nt_sel}, 1);
      chk("R1", {28'b0, mw_cs2, mw_cs1, mw_clk, mw_do}, 0);
   endtask

   task automatic t_decode;
      wr(16'h50A5, 8'h25);               // low byte ignored
      prg_at("R2", 16'h8123, ref_prg(8'h25, 2'b0, 1'b0));
      wr(16'h5425, 8'h1A);               // unmapped page
      wr(16'h4000, 8'h1A);
      wr(16'h7052, 8'h55);
      prg_at("R2", 16'h8000, ref_prg(8'h25, 2'b0, 1'b0));
      chk("R2", {28'b0, mw_cs2, mw_cs1, mw_clk, mw_do}, 0);
   endtask

   task automatic t_mode16;
      wr(16'h5000, 8'h25);
      prg_at("R3", 16'h8000, ref_prg(8'h25, 2'b0, 1'b0));
      wr(16'h5000, 8'h1A & 8'h0F);
      prg_at("R3", 16'hB000, ref_prg(8'h0A, 2'b0, 1'b0));
      prg_at("R4", 16'hC000, 7'h1F);
      wr(16'h5000, 8'h41);
      prg_at("R4", 16'hE000, ref_prg(8'h41, 2'b0, 1'b1));
      wr(16'h5000, 8'h40);
      prg_at("R4", 16'hFFFF, 7'h1C);
      wr(16'h5000, 8'h43);
      prg_at("R4", 16'hC000, 7'h1E);
   endtask

   task automatic t_mode32;
      wr(16'h5000, 8'h1A);
      prg_at("R5", 16'h8000, ref_prg(8'h1A, 2'b0, 1'b0));
      prg_at("R5", 16'hC000, ref_prg(8'h1A, 2'b0, 1'b1));
      wr(16'h5000, 8'h75);
      prg_at("R5", 16'hC000, 7'h0B);
   endtask

   task automatic t_high;
      wr(16'h5100, 8'hFE);
      prg_at("R6", 16'hC000, ref_prg(8'h75, 2'b10, 1'b1));
      wr(16'h5000, 8'h00);
      wr(16'h5100, 8'h03);
      prg_at("R6", 16'hC000, 7'h7F);
      prg_at("R6", 16'h8000, 7'h60);
      wr(16'h5100, 8'h00);
   endtask

   task automatic t_mirror;
      wr(16'h5300, 8'h00);
      wr(16'h5000, 8'h00);
      ppu_addr = 14'h2800;                // A11=1, A10=0
      #1 chk("R7", {31'b0, nt_sel}, 0);   // forced vertical
      wr(16'h5000, 8'h10);
      #1 chk("R7", {31'b0, nt_sel}, 1);   // horizontal
      wr(16'h5300, 8'h80);
      #1 chk("R7", {31'b0, nt_sel}, 0);   // vertical
      ppu_addr = 14'h2400;
      #1 chk("R7", {31'b0, nt_sel}, 1);
      wr(16'h5000, 8'h00);
   endtask

   task automatic t_serial;
      wr(16'h5200, 8'h55);
      chk("R8", {28'b0, mw_cs2, mw_cs1, mw_clk, mw_do}, 4'hF);
      wr(16'h52FF, 8'h14);
      chk("R8", {28'b0, mw_cs2, mw_cs1, mw_clk, mw_do}, 4'b0110);
      wr(16'h5200, 8'hAA);
      chk("R8", {28'b0, mw_cs2, mw_cs1, mw_clk, mw_do}, 4'b0000);
   endtask

   task automatic t_read;
      @(negedge clk);
      cpu_addr = 16'h5500; cpu_re = 1'b1; mw_di = 1'b0;
      #1 chk("R9", {23'b0, cpu_rdata_oe, cpu_rdata}, {23'b0, 1'b1, 8'h04});
      mw_di = 1'b1;
      #1 chk("R9", {23'b0, cpu_rdata_oe, cpu_rdata}, {23'b0, 1'b1, 8'h00});
      cpu_addr = 16'h5400; mw_di = 1'b0;
      #1 chk("R9", {23'b0, cpu_rdata_oe, cpu_rdata}, 0);
      cpu_addr = 16'h5500; cpu_re = 1'b0;
      #1 chk("R9", {23'b0, cpu_rdata_oe, cpu_rdata}, 0);
   endtask

   task automatic t_bitmap;
      ppu_addr = 14'h0000;
      wr(16'h5000, 8'h00);
      ppu_addr = 14'h1FF7;
      #1 chk("R10", {19'b0, chr_addr}, {19'b0, 13'h1FF7});
      wr(16'h5000, 8'h80);
      @(negedge clk); ppu_addr = 14'h2201;   // A13 rise, A9=1, A0=1
      @(negedge clk); ppu_addr = 14'h2000;   // still high, not captured
      @(negedge clk); ppu_addr = 14'h0000;
      #1 chk("R10", {19'b0, chr_addr}, {19'b0, 13'h1008});
      ppu_addr = 14'h1FF7;
      #1 chk("R10", {19'b0, chr_addr}, {19'b0, 13'h1FFF});
      @(negedge clk); ppu_addr = 14'h2000;   // rise with A0=A9=0
      @(negedge clk); ppu_addr = 14'h1FFF;
      #1 chk("R10", {19'b0, chr_addr}, {19'b0, 13'h0FF7});
      ppu_addr = 14'h3FFF;
      #1 chk("R10", {19'b0, chr_addr}, {19'b0, 13'h1FFF});
      wr(16'h5000, 8'h00);
   endtask

   task automatic t_ram;
      @(negedge clk);
      cpu_addr = 16'h6000;
      #1 chk("R11", {31'b0, prg_ram_cs}, 1);
      cpu_addr = 16'h7FFF;
      #1 chk("R11", {20'b0, prg_ram_cs, prg_ram_addr}, {20'b0, 1'b1, 11'h7FF});
      cpu_addr = 16'h6A05;
      #1 chk("R11", {21'b0, prg_ram_addr}, {21'b0, 11'h205});
      cpu_addr = 16'h5FFF;
      #1 chk("R11", {31'b0, prg_ram_cs}, 0);
      cpu_addr = 16'h8000;
      #1 chk("R11", {31'b0, prg_ram_cs}, 0);
   endtask

   initial begin
      fork
         begin
            repeat (3) @(negedge clk);
            rst_n = 1'b1;
            t_reset();
            t_decode();
            t_mode16();
            t_mode32();
            t_high();
            t_mirror();
            t_serial();
            t_read();
            t_bitmap();
            t_ram();
         end
         begin
            repeat (5000) @(posedge clk);
            checks++; errors++;
            $display("FAIL watchdog actual=timeout expected=done");
         end
      join_any
      disable fork;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule